// File: doc/BRIEF.md
# Transmit Start and Interframe Gap Gate

This block decides when a frame that is queued in a transmit FIFO may begin to go out on an 8-bit, byte-clocked transmit path. A frame may be released in two ways. The first is when the FIFO fill level reaches a configured threshold. The second is when the FIFO reports that it holds a whole frame, and this works whatever the threshold is. When either holds, the gate gives the framer a one-cycle start pulse. It then waits for the framer to report that the frame's transmit enable has dropped.

After that falling edge the gate holds back the next start for a minimum idle time. The idle time is a count of byte-clock cycles taken from a static configuration input. A setting of 12 gives the standard 96 bit times. The gap length is captured when the falling edge is reported, so a new value written while a gap is running applies only to the next gap. Coming out of reset, the gap counts as already elapsed.

Top module: `tx_start_gate`

## Requirements
- R1: While rst_ni is low, start_o is low. After reset is released, no gap is pending: if the start condition holds at the first rising edge, start_o is high in the following cycle.
- R2: In the idle state, fill_level_i >= thresh_i (unsigned comparison, equal values included) is a start condition. A threshold of 0 always meets it.
- R3: In the idle state, frame_ready_i high is a start condition whatever fill_level_i and thresh_i are.
- R4: When fill_level_i < thresh_i and frame_ready_i is low, start_o stays low.
- R5: start_o is high for exactly one cycle. It rises in the cycle after the clock edge at which the idle state and a start condition were both sampled.
- R6: After a start, start_o stays low until ten_fell_i has been sampled high, even if the start condition keeps holding.
- R7: If ten_fell_i is sampled high at edge E0 with gap_len_i = G, the earliest next start_o is high after edge E0+G+1. This leaves G idle gap cycles. G = 0 is allowed, and the default setting of 12 cycles equals 96 bit times.
- R8: gap_len_i is captured at the edge that accepts ten_fell_i. Changing it during a running gap does not change that gap's length.
- R9: ten_fell_i is ignored when no frame is in flight. A pulse while idle does not delay the next start, and a pulse during a running gap does not restart the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_level_i | input | LVL_W | Current transmit FIFO fill level |
| thresh_i | input | LVL_W | Fill level that allows a start |
| frame_ready_i | input | 1 | A complete frame is held in the FIFO |
| gap_len_i | input | GAP_W | Minimum idle gap in byte-clock cycles |
| ten_fell_i | input | 1 | One-cycle pulse from the framer: transmit enable fell |
| start_o | output | 1 | One-cycle permission to start the next frame |

## Verification
The bench builds the gate with LVL_W = 6 and GAP_W = 5. At these widths it can drive fill levels and thresholds at 0 and at the top of the range (63). It can also drive the longest gap of 31 cycles, a zero gap and the default of 12. In every case it measures the exact edge at which the next start pulse appears. The narrow widths also keep short the directed cases for a gap value changed mid-count, stray transmit-enable-fell pulses, and reset during a frame.

// File: rtl/tx_gate_pkg.sv
package tx_gate_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_GAP  = 2'd2
  } gate_state_e;

  localparam int unsigned GAP_DEFAULT = 12;  // 96 bit times on an 8-bit path
endpackage

// File: rtl/tx_start_cond.sv
module tx_start_cond #(
  parameter int unsigned LVL_W = 8
) (
  input  logic [LVL_W-1:0] fill_level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             frame_ready_i,
  output logic             cond_o
);
  logic lvl_ok;

  assign lvl_ok = (fill_level_i >= thresh_i);
  assign cond_o = lvl_ok | frame_ready_i;
endmodule

// File: rtl/tx_gap_timer.sv
module tx_gap_timer #(
  parameter int unsigned GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [GAP_W-1:0] len_i,
  output logic             busy_o,
  output logic             expire_o
);
  logic [GAP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - GAP_W'(1);
    end
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == GAP_W'(1));

  assert_expire_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !load_i) |=> !busy_o);

  assert_load_starts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i != '0) |=> busy_o);
endmodule

// File: rtl/tx_start_seq.sv
module tx_start_seq
  import tx_gate_pkg::*;
#(
  parameter int unsigned GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cond_i,
  input  logic             ten_fell_i,
  input  logic [GAP_W-1:0] gap_len_i,
  input  logic             expire_i,
  output logic             load_o,
  output logic             start_o
);
  gate_state_e state_q, state_d;
  logic        start_q;

  assign load_o = (state_q == ST_BUSY) && ten_fell_i && (gap_len_i != '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cond_i) state_d = ST_BUSY;
      ST_BUSY: if (ten_fell_i) state_d = (gap_len_i == '0) ? ST_IDLE : ST_GAP;
      ST_GAP:  if (expire_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  // gap treated as elapsed
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == ST_IDLE) && cond_i;
    end
  end

  assign start_o = start_q;

  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_hold_until_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && !ten_fell_i) |=> !start_o);

  assert_start_has_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(start_o) |-> $past(cond_i));
endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
  import tx_gate_pkg::*;
#(
  parameter int unsigned LVL_W = 8,
  parameter int unsigned GAP_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] fill_level_i,
  input  logic [LVL_W-1:0] thresh_i,
  input  logic             frame_ready_i,
  input  logic [GAP_W-1:0] gap_len_i,
  input  logic             ten_fell_i,
  output logic             start_o
);
  logic cond;
  logic load;
  logic gap_busy;
  logic gap_expire;

  tx_start_cond #(.LVL_W(LVL_W)) u_cond (
    .fill_level_i (fill_level_i),
    .thresh_i     (thresh_i),
    .frame_ready_i(frame_ready_i),
    .cond_o       (cond)
  );

  tx_gap_timer #(.GAP_W(GAP_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .len_i   (gap_len_i),
    .busy_o  (gap_busy),
    .expire_o(gap_expire)
  );

  tx_start_seq #(.GAP_W(GAP_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cond_i    (cond),
    .ten_fell_i(ten_fell_i),
    .gap_len_i (gap_len_i),
    .expire_i  (gap_expire),
    .load_o    (load),
    .start_o   (start_o)
  );

  assert_no_start_in_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_busy |=> !start_o);

  assert_no_start_without_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cond && !start_o) |=> !start_o);
endmodule

// File: tb/tx_start_gate_tb_top.sv
module tx_start_gate_tb_top;
  localparam int unsigned LVL_W = 6;
  localparam int unsigned GAP_W = 5;

  typedef struct packed {
    logic [LVL_W-1:0] fill;
    logic [LVL_W-1:0] thr;
    logic             rdy;
    logic [GAP_W-1:0] gap;
    logic             exp_start;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{6'd10, 6'd10, 1'b0, 5'd12, 1'b1},  // R2 equal, default gap
    '{6'd9,  6'd10, 1'b0, 5'd12, 1'b0},  // R4
    '{6'd0,  6'd20, 1'b1, 5'd3,  1'b1},  // R3
    '{6'd63, 6'd1,  1'b0, 5'd0,  1'b1},  // R2, zero gap
    '{6'd5,  6'd6,  1'b0, 5'd4,  1'b0},  // R4
    '{6'd0,  6'd0,  1'b0, 5'd1,  1'b1},  // R2 threshold zero
    '{6'd31, 6'd32, 1'b1, 5'd31, 1'b1},  // R3, longest gap
    '{6'd0,  6'd63, 1'b0, 5'd2,  1'b0}   // R4
  };

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [LVL_W-1:0] fill_level_i = '0;
  logic [LVL_W-1:0] thresh_i = '1;
  logic             frame_ready_i = 1'b0;
  logic [GAP_W-1:0] gap_len_i = GAP_W'(tx_gate_pkg::GAP_DEFAULT);
  logic             ten_fell_i = 1'b0;
  logic             start_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  tx_start_gate #(.LVL_W(LVL_W), .GAP_W(GAP_W)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_level_i (fill_level_i),
    .thresh_i     (thresh_i),
    .frame_ready_i(frame_ready_i),
    .gap_len_i    (gap_len_i),
    .ten_fell_i   (ten_fell_i),
    .start_o      (start_o)
  );

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns edges after the ten_fell edge until start_o is seen
  task automatic measure_gap(input int gap, output int n);
    gap_len_i  = GAP_W'(gap);
    ten_fell_i = 1'b1;
    step();
    ten_fell_i = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      n++;
      if (start_o) break;
    end
  endtask

  task automatic finish_frame();
    frame_ready_i = 1'b0;
    fill_level_i  = '0;
    thresh_i      = '1;
    gap_len_i     = '0;
    ten_fell_i    = 1'b1;
    step();
    ten_fell_i = 1'b0;
    step();
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    // R1 reset state with a frame already waiting
    frame_ready_i = 1'b1;
    repeat (3) step();
    check(start_o == 1'b0, "R1 reset low", start_o, 0);
    rst_ni = 1'b1;
    step();
    check(start_o == 1'b1, "R1 first start right after reset", start_o, 1);
    finish_frame();

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      fill_level_i  = VECS[i].fill;
      thresh_i      = VECS[i].thr;
      frame_ready_i = VECS[i].rdy;
      step();
      check(start_o == VECS[i].exp_start, $sformatf("R2/R3/R4 vec %0d start", i),
            start_o, VECS[i].exp_start);
      if (VECS[i].exp_start) begin
        step();
        check(start_o == 1'b0, $sformatf("R5 vec %0d one pulse", i), start_o, 0);
        for (int k = 0; k < 4; k++) begin
          step();
          check(start_o == 1'b0, $sformatf("R6 vec %0d held", i), start_o, 0);
        end
        measure_gap(VECS[i].gap, n);
        check(n == VECS[i].gap + 1, $sformatf("R7 vec %0d gap", i), n, VECS[i].gap + 1);
        finish_frame();
      end else begin
        for (int k = 0; k < 3; k++) begin
          step();
          check(start_o == 1'b0, $sformatf("R4 vec %0d quiet", i), start_o, 0);
        end
        finish_frame();
      end
    end

    // R8 gap value changed mid-count
    frame_ready_i = 1'b1;
    step();
    check(start_o == 1'b1, "R8 setup start", start_o, 1);
    gap_len_i  = 5'd10;
    ten_fell_i = 1'b1;
    step();
    ten_fell_i = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      n++;
      if (n == 3) gap_len_i = 5'd2;
      if (start_o) break;
    end
    check(n == 11, "R8 gap length latched", n, 11);
    finish_frame();

    // R9 ten_fell pulse during gap does not restart it
    frame_ready_i = 1'b1;
    step();
    gap_len_i  = 5'd8;
    ten_fell_i = 1'b1;
    step();
    ten_fell_i = 1'b0;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      step();
      n++;
      ten_fell_i = (n == 4);
      if (start_o) break;
    end
    ten_fell_i = 1'b0;
    check(n == 9, "R9 gap not restarted", n, 9);
    finish_frame();

    // R9 ten_fell pulse while idle is ignored
    gap_len_i  = 5'd20;
    ten_fell_i = 1'b1;
    step();
    ten_fell_i    = 1'b0;
    frame_ready_i = 1'b1;
    step();
    check(start_o == 1'b1, "R9 idle pulse ignored", start_o, 1);
    finish_frame();

    // R1 reset during a frame clears the wait
    frame_ready_i = 1'b1;
    step();
    step();
    rst_ni = 1'b0;
    step();
    check(start_o == 1'b0, "R1 reset mid-frame", start_o, 0);
    rst_ni = 1'b1;
    step();
    check(start_o == 1'b1, "R1 start after mid-frame reset", start_o, 1);
    finish_frame();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule